// File: doc/BRIEF.md
# RV32I Integer Arithmetic-Logic Unit with Field Decode

This block executes the integer computational instructions of the 32-bit base RISC-V set. It takes a full 32-bit instruction word and two 32-bit register values. It picks its operation from the opcode, funct3 and funct7 fields of the word and returns a 32-bit result in the same cycle. Register-register instructions use the second register value as their second operand. Register-immediate instructions use the sign-extended 12-bit immediate from bits 31:20 of the word instead.

The result goes to a write-back path owned by a neighbouring block. The unit ignores the destination and source register index fields; register read and write happen outside it. Any encoding that the unit does not implement raises an illegal-operation flag and forces the result to zero. The pipeline can then trap without writing a stray value.

Top module: `rv32i_alu`

## Requirements
- R1: Only opcode 0110011 (register form) and 0010011 (immediate form) are accepted; any other opcode raises `illegal` and drives `result` to zero.
- R2: funct3 000 with funct7 0000000 adds the operands modulo 2^32; in immediate form the second operand is instWord[31:20] sign-extended to 32 bits.
- R3: Register form with funct3 000 and funct7 0100000 subtracts (rs1 minus rs2, modulo 2^32); immediate form with funct3 000 always adds, whatever bits 31:25 hold.
- R4: funct3 010 gives 1 when the first operand is less than the second as two's-complement values and 0 otherwise.
- R5: funct3 011 gives the same 1/0 result under unsigned comparison; in immediate form the immediate is sign-extended before the unsigned compare.
- R6: funct3 100, 110 and 111 give bitwise XOR, OR and AND of the operands, in both forms.
- R7: funct3 001 shifts left, filling with zeros, by the low 5 bits of rs2 (register form) or of instWord[24:20] (immediate form).
- R8: funct3 101 shifts right by the same 5-bit amount, filling with zeros when bits 31:25 are 0000000 and with copies of bit 31 of the operand when they are 0100000.
- R9: In register form, a funct7 other than 0000000 or 0100000, or funct7 0100000 with a funct3 other than 000 or 101, raises `illegal`.
- R10: In immediate form, funct3 001 with bits 31:25 not 0000000, or funct3 101 with bits 31:25 neither 0000000 nor 0100000, raises `illegal`.
- R11: Whenever `illegal` is 1, `result` is 0; whenever a supported encoding is presented, `illegal` is 0.
- R12: The word 0x015A04B3 is a legal register-form add, and its result is rs1Val plus rs2Val.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instWord | input | 32 | Instruction word supplying opcode, funct3, funct7 and immediate |
| rs1Val | input | 32 | First operand |
| rs2Val | input | 32 | Second operand for register-form instructions |
| result | output | 32 | Operation result, zero when illegal |
| illegal | output | 1 | High for an encoding the unit does not support |

## Verification
The hardest case to reach is an immediate shift whose upper immediate bits collide with the funct7 position. In that form, the same seven bits are either part of a number (addi, andi, and the others) or a variant selector that must be checked (slli, srli, srai). The stimulus therefore builds immediates whose bits 11:5 equal 0100000 or a stray pattern. It places them under funct3 000, 001 and 101. This shows that the pattern subtracts nothing in addi, selects arithmetic shift in srai, and is rejected in slli. Shift amounts above 31 in rs2 show that only 5 bits count.

// File: rtl/rv32i_alu_pkg.sv
package rv32i_alu_pkg;

  typedef enum logic [2:0] {
    SEL_ADD  = 3'd0,
    SEL_SLL  = 3'd1,
    SEL_SLT  = 3'd2,
    SEL_SLTU = 3'd3,
    SEL_XOR  = 3'd4,
    SEL_SHR  = 3'd5,
    SEL_OR   = 3'd6,
    SEL_AND  = 3'd7
  } aluSel_e;

  typedef struct packed {
    aluSel_e sel;
    logic    negB;
    logic    arith;
    logic    useImm;
    logic    illegal;
  } aluCtrl_t;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

endpackage

// File: rtl/rv32i_alu_decode.sv
module rv32i_alu_decode
  import rv32i_alu_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output aluCtrl_t   ctrl
);

  logic isReg;
  logic isImm;
  logic f7Base;
  logic f7Alt;

  assign isReg  = (opcode == OPC_REG);
  assign isImm  = (opcode == OPC_IMM);
  assign f7Base = (funct7 == F7_BASE);
  assign f7Alt  = (funct7 == F7_ALT);

  always_comb begin
    ctrl.sel     = aluSel_e'(funct3);
    ctrl.negB    = 1'b0;
    ctrl.arith   = 1'b0;
    ctrl.useImm  = isImm;
    ctrl.illegal = 1'b0;

    if (isReg) begin
      if (f7Alt) begin
        ctrl.negB    = (funct3 == 3'b000);
        ctrl.arith   = (funct3 == 3'b101);
        ctrl.illegal = !((funct3 == 3'b000) || (funct3 == 3'b101));
      end else if (!f7Base) begin
        ctrl.illegal = 1'b1;
      end
    end else if (isImm) begin
      unique case (funct3)
        3'b001:  ctrl.illegal = !f7Base;
        3'b101: begin
          ctrl.arith   = f7Alt;
          ctrl.illegal = !(f7Base || f7Alt);
        end
        default: ctrl.illegal = 1'b0;
      endcase
    end else begin
      ctrl.illegal = 1'b1;
    end
  end

endmodule

// File: rtl/rv32i_alu_datapath.sv
module rv32i_alu_datapath
  import rv32i_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluCtrl_t        ctrl,
  output logic [XLEN-1:0] result
);

  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] bEff;
  logic [XLEN-1:0] sum;
  logic [SHW-1:0]  shAmt;
  logic            ltSigned;
  logic            ltUnsigned;
  logic [XLEN-1:0] shRight;
  logic [XLEN-1:0] raw;

  assign bEff       = ctrl.negB ? ~opB : opB;
  assign sum        = opA + bEff + {{(XLEN-1){1'b0}}, ctrl.negB};
  assign shAmt      = opB[SHW-1:0];
  assign ltSigned   = ($signed(opA) < $signed(opB));
  assign ltUnsigned = (opA < opB);
  assign shRight    = ctrl.arith ? XLEN'($signed(opA) >>> shAmt) : (opA >> shAmt);

  always_comb begin
    unique case (ctrl.sel)
      SEL_ADD:  raw = sum;
      SEL_SLL:  raw = opA << shAmt;
      SEL_SLT:  raw = {{(XLEN-1){1'b0}}, ltSigned};
      SEL_SLTU: raw = {{(XLEN-1){1'b0}}, ltUnsigned};
      SEL_XOR:  raw = opA ^ opB;
      SEL_SHR:  raw = shRight;
      SEL_OR:   raw = opA | opB;
      SEL_AND:  raw = opA & opB;
      default:  raw = '0;
    endcase
  end

  assign result = ctrl.illegal ? '0 : raw;

endmodule

// File: rtl/rv32i_alu.sv
module rv32i_alu
  import rv32i_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] rs1Val,
  input  logic [XLEN-1:0] rs2Val,
  output logic [XLEN-1:0] result,
  output logic            illegal
);

  localparam int IMMW = 12;

  aluCtrl_t        ctrl;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] opB;
  logic            unusedRegFields;

  assign unusedRegFields = ^instWord[19:7];

  rv32i_alu_decode u_decode (
    .opcode (instWord[6:0]),
    .funct3 (instWord[14:12]),
    .funct7 (instWord[31:25]),
    .ctrl   (ctrl)
  );

  assign immExt = {{(XLEN-IMMW){instWord[31]}}, instWord[31:20]};
  assign opB    = ctrl.useImm ? immExt : rs2Val;

  rv32i_alu_datapath #(.XLEN(XLEN)) u_datapath (
    .opA    (rs1Val),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result)
  );

  assign illegal = ctrl.illegal;

endmodule

// File: rtl/rv32i_alu_chk.sv
module rv32i_alu_chk (
  input logic [31:0] instWord,
  input logic [31:0] result,
  input logic        illegal
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       known;

  assign opc   = instWord[6:0];
  assign f3    = instWord[14:12];
  assign f7    = instWord[31:25];
  assign known = !$isunknown({instWord, result, illegal});

  always_comb begin
    if (known) begin
      // R11: a rejected encoding never leaks a value
      a_r11_illegal_zero: assert (!illegal || result == 32'd0);
      // R1: foreign opcodes are rejected
      a_r1_bad_opcode: assert ((opc == 7'b0110011) || (opc == 7'b0010011) || illegal);
      // R3: immediate add never rejected, whatever the upper immediate bits
      a_r3_addi_legal: assert (!((opc == 7'b0010011) && (f3 == 3'b000)) || !illegal);
      // R9: stray funct7 in register form is rejected
      a_r9_bad_funct7: assert (!((opc == 7'b0110011) && (f7 != 7'b0000000) && (f7 != 7'b0100000)) || illegal);
      // R4: comparisons yield a single-bit value
      a_r4_compare_bit: assert (!((f3 == 3'b010) || (f3 == 3'b011)) || (result[31:1] == 31'd0));
    end
  end

endmodule

bind rv32i_alu rv32i_alu_chk u_chk (
  .instWord (instWord),
  .result   (result),
  .illegal  (illegal)
);

// File: tb/rv32i_alu_tb.sv
module rv32i_alu_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] inst;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] rForm(input logic [6:0] f7, input logic [2:0] f3);
    return {f7, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
  endfunction

  function automatic logic [31:0] iForm(input logic [11:0] imm, input logic [2:0] f3);
    return {imm, 5'd1, f3, 5'd3, 7'b0010011};
  endfunction

  localparam int NVEC = 28;
  localparam vec_t VEC [NVEC] = '{
    '{rForm(7'h00, 3'd0), 32'd5,         32'd7,         32'd12,        1'b0, 4'd2},  // R2 add
    '{rForm(7'h00, 3'd0), 32'hFFFFFFFF,  32'd2,         32'd1,         1'b0, 4'd2},  // R2 wrap
    '{iForm(12'hFFF, 3'd0), 32'd10,      32'h1234,      32'd9,         1'b0, 4'd2},  // R2 addi -1
    '{rForm(7'h20, 3'd0), 32'd5,         32'd7,         32'hFFFFFFFE,  1'b0, 4'd3},  // R3 sub
    '{iForm(12'h400, 3'd0), 32'd1,       32'd0,         32'h00000401,  1'b0, 4'd3},  // R3 no sub-imm
    '{rForm(7'h00, 3'd2), 32'hFFFFFFFF,  32'd1,         32'd1,         1'b0, 4'd4},  // R4 slt
    '{rForm(7'h00, 3'd2), 32'd1,         32'hFFFFFFFF,  32'd0,         1'b0, 4'd4},  // R4 slt
    '{iForm(12'h800, 3'd2), 32'h80000000, 32'd0,        32'd1,         1'b0, 4'd4},  // R4 slti
    '{rForm(7'h00, 3'd3), 32'd1,         32'hFFFFFFFF,  32'd1,         1'b0, 4'd5},  // R5 sltu
    '{rForm(7'h00, 3'd3), 32'hFFFFFFFF,  32'd1,         32'd0,         1'b0, 4'd5},  // R5 sltu
    '{iForm(12'hFFF, 3'd3), 32'd5,       32'd0,         32'd1,         1'b0, 4'd5},  // R5 sltiu
    '{rForm(7'h00, 3'd4), 32'hF0F0F0F0,  32'hFF00FF00,  32'h0FF00FF0,  1'b0, 4'd6},  // R6 xor
    '{rForm(7'h00, 3'd6), 32'hF0F0F0F0,  32'hFF00FF00,  32'hFFF0FFF0,  1'b0, 4'd6},  // R6 or
    '{rForm(7'h00, 3'd7), 32'hF0F0F0F0,  32'hFF00FF00,  32'hF000F000,  1'b0, 4'd6},  // R6 and
    '{iForm(12'h0FF, 3'd7), 32'h12345678, 32'd0,        32'h00000078,  1'b0, 4'd6},  // R6 andi
    '{iForm(12'h800, 3'd6), 32'd0,       32'd0,         32'hFFFFF800,  1'b0, 4'd6},  // R6 ori
    '{rForm(7'h00, 3'd1), 32'd1,         32'h00000023,  32'd8,         1'b0, 4'd7},  // R7 sll 5-bit
    '{iForm(12'h01F, 3'd1), 32'd1,       32'd0,         32'h80000000,  1'b0, 4'd7},  // R7 slli
    '{rForm(7'h00, 3'd5), 32'h80000000,  32'd4,         32'h08000000,  1'b0, 4'd8},  // R8 srl
    '{rForm(7'h20, 3'd5), 32'h80000000,  32'd4,         32'hF8000000,  1'b0, 4'd8},  // R8 sra
    '{iForm(12'h404, 3'd5), 32'hF0000000, 32'd0,        32'hFF000000,  1'b0, 4'd8},  // R8 srai
    '{iForm(12'h004, 3'd5), 32'hF0000000, 32'd0,        32'h0F000000,  1'b0, 4'd8},  // R8 srli
    '{rForm(7'h01, 3'd0), 32'd5,         32'd7,         32'd0,         1'b1, 4'd9},  // R9 stray funct7
    '{rForm(7'h20, 3'd4), 32'd5,         32'd7,         32'd0,         1'b1, 4'd9},  // R9 alt xor
    '{iForm(12'h401, 3'd1), 32'd5,       32'd0,         32'd0,         1'b1, 4'd10}, // R10 slli alt
    '{iForm(12'h604, 3'd5), 32'd5,       32'd0,         32'd0,         1'b1, 4'd10}, // R10 shift stray
    '{32'h00002003,       32'd5,         32'd7,         32'd0,         1'b1, 4'd1},  // R1 R11 load opcode
    '{32'h015A04B3,       32'd100,       32'd23,        32'd123,       1'b0, 4'd12}  // R12 known word
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] instWord;
  logic [31:0] rs1Val;
  logic [31:0] rs2Val;
  logic [31:0] result;
  logic        illegal;
  int          nChecks;
  int          nFails;
  logic        done;

  rv32i_alu u_dut (
    .instWord (instWord),
    .rs1Val   (rs1Val),
    .rs2Val   (rs2Val),
    .result   (result),
    .illegal  (illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    instWord = i;
    rs1Val   = a;
    rs2Val   = b;
    @(negedge clk);
  endtask

  initial begin
    nChecks  = 0;
    nFails   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    instWord = '0;
    rs1Val   = '0;
    rs2Val   = '0;
    repeat (2) @(negedge clk);
    // R1 R11: all-zero word after reset is a foreign opcode
    check("R1 reset illegal", {31'd0, illegal}, 32'd1);
    check("R11 reset result", result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].inst, VEC[i].a, VEC[i].b);
      check($sformatf("R%0d result vec%0d", VEC[i].req, i), result, VEC[i].exp);
      check($sformatf("R%0d flag vec%0d", VEC[i].req, i), {31'd0, illegal}, {31'd0, VEC[i].ill});
    end

    // R8: arithmetic shift by 31 fills whole word
    apply(rForm(7'h20, 3'd5), 32'h80000000, 32'd31);
    check("R8 sra by 31", result, 32'hFFFFFFFF);
    // R7: zero shift is identity
    apply(rForm(7'h00, 3'd1), 32'hDEADBEEF, 32'h00000020);
    check("R7 sll by 0", result, 32'hDEADBEEF);
    // R3: negating the most negative value wraps
    apply(rForm(7'h20, 3'd0), 32'd0, 32'h80000000);
    check("R3 sub wrap", result, 32'h80000000);
    // R4: equal operands are not less
    apply(iForm(12'h800, 3'd2), 32'hFFFFF800, 32'd0);
    check("R4 slti equal", result, 32'd0);
    // R10: srai pattern is legal only with 0100000
    apply(iForm(12'h41F, 3'd5), 32'h40000000, 32'd0);
    check("R10 srai legal flag", {31'd0, illegal}, 32'd0);
    check("R8 srai positive", result, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule